// File: doc/BRIEF.md
# Microprogram Sequencer with Status-Selected Branch

This block steps through a writable control store of 1024 microwords, each 26 bits wide. Every microword carries a 13-bit micro-operation group that is presented to the controlled datapath, a 3-bit condition selector and a 10-bit branch target. On every clock edge the sequencer uses the selector of the word it is presenting to pick one of eight status inputs. If that status bit is 1, the sequencer jumps to the branch target. If it is 0, it falls through to the following address. There is only one target per word, so an unconditional jump uses a status line that is tied high, and straight-line code uses a line that is tied low.

The control store is loaded through a one-cycle write port. The port is normally used while reset is held, and it may also be used while the sequencer runs. A write stalls sequencing. After a write, the word at the current address is fetched again, so a patch to the running word takes effect. The read is synchronous: the next address is computed combinationally and drives the store's read port, so the registered micro-operation output always belongs to the address shown on the address output.

Top module: `useq_top`

## Requirements
- R1: A microword holds the micro-operation in bits [25:13], the condition selector in bits [12:10] and the branch target in bits [9:0]. While the valid output is 1, the micro-operation output equals bits [25:13] of the stored word at the address on the address output.
- R2: On a clock edge with the valid output at 1 and no write, if the selected status bit is 1, the address output takes the branch target of the presented word.
- R3: On such an edge with the selected status bit at 0, the address output takes the current address plus one, modulo 1024, so address 1023 is followed by 0.
- R4: Selector value k (0 to 7) chooses status input bit k.
- R5: While reset is asserted (active low, asynchronous), the address, the micro-operation and the valid output are all 0. Reset release takes effect after two clock edges. The next edge fetches word 0, sets valid to 1 and keeps the address at 0.
- R6: An edge with the write enable at 1 stores the write data at the write address. That edge holds the address and the micro-operation output and clears valid. Writes are accepted during reset.
- R7: The first edge without a write after a write, or after the first fetch wait, keeps the address and presents the word now stored there, with valid at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| status_i | input | 8 | Condition inputs chosen by the selector field |
| we_i | input | 1 | Control-store write enable |
| waddr_i | input | 10 | Control-store write address |
| wdata_i | input | 26 | Microword to store |
| uop_o | output | 13 | Micro-operation bits of the presented word |
| uaddr_o | output | 10 | Control address register |
| uop_vld_o | output | 1 | Presented word matches the current address |

## Verification
The bound checker checks the per-edge sequencing rules on every cycle. It checks the branch to the target on a selected 1 and the increment with wrap on a selected 0. It also checks that a write edge freezes the address and the micro-operation and drops valid. Only the bench scenarios can show some other behaviours. These are the two-edge reset release, the fetch of word 0, the refetch of a word patched in place, and the match between the output and the stored content. The scenarios also show that each of the eight selector values reaches its own status line and that address 1023 wraps to 0.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned UOP_W  = 13;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned ADR_W  = 10;
  localparam int unsigned WORD_W = UOP_W + SEL_W + ADR_W;
  localparam int unsigned N_COND = 1 << SEL_W;
  localparam int unsigned DEPTH  = 1 << ADR_W;
  localparam int unsigned SYNC_STAGES = 2;

  // field order is decoded by the sequencer: op on top, target at the bottom
  typedef struct packed {
    logic [UOP_W-1:0] uop;
    logic [SEL_W-1:0] sel;
    logic [ADR_W-1:0] tgt;
  } uword_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [ADR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [ADR_W-1:0] raddr_i,
  output uword_t           word_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  uword_t            word_q;
  uword_t            word_d;

  // storage array carries no reset so it can be loaded while reset is held
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    word_d = word_q;
    if (re_i) begin
      word_d = uword_t'(mem[raddr_i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  logic [N_COND-1:0] status_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              cond_o
);
  logic [N_COND-1:0] hit;

  for (genvar k = 0; k < N_COND; k++) begin : g_leg
    assign hit[k] = status_i[k] && (sel_i == SEL_W'(k));
  end

  assign cond_o = |hit;
endmodule

// File: rtl/useq_addr_seq.sv
module useq_addr_seq
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             cond_i,
  input  logic [ADR_W-1:0] tgt_i,
  output logic [ADR_W-1:0] car_o,
  output logic [ADR_W-1:0] car_nxt_o,
  output logic             run_o
);
  logic [ADR_W-1:0] car_q;
  logic [ADR_W-1:0] car_d;
  logic             run_q;
  logic             run_d;
  logic             car_en;

  always_comb begin
    car_en = !we_i;
    run_d  = !we_i;
    if (!run_q) begin
      car_d = car_q;
    end else if (cond_i) begin
      car_d = tgt_i;
    end else begin
      car_d = car_q + ADR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (car_en) begin
        car_q <= car_d;
      end
    end
  end

  assign car_o     = car_q;
  assign car_nxt_o = car_d;
  assign run_o     = run_q;
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COND-1:0] status_i,
  input  logic              we_i,
  input  logic [ADR_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [UOP_W-1:0]  uop_o,
  output logic [ADR_W-1:0]  uaddr_o,
  output logic              uop_vld_o
);
  logic             rst_sn;
  uword_t           word_q;
  logic             cond;
  logic [ADR_W-1:0] car_q;
  logic [ADR_W-1:0] car_nxt;
  logic             run_q;

  useq_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  useq_cond_mux i_cond_mux (
    .status_i (status_i),
    .sel_i    (word_q.sel),
    .cond_o   (cond)
  );

  useq_addr_seq i_addr_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .we_i      (we_i),
    .cond_i    (cond),
    .tgt_i     (word_q.tgt),
    .car_o     (car_q),
    .car_nxt_o (car_nxt),
    .run_o     (run_q)
  );

  useq_ctrl_store i_ctrl_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .re_i    (!we_i),
    .raddr_i (car_nxt),
    .word_o  (word_q)
  );

  assign uop_o     = word_q.uop;
  assign uaddr_o   = car_q;
  assign uop_vld_o = run_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [N_COND-1:0] status_i,
  input logic              we_i,
  input logic [UOP_W-1:0]  uop_o,
  input logic [ADR_W-1:0]  uaddr_o,
  input logic              uop_vld_o,
  input logic [WORD_W-1:0] word_i
);
  logic [SEL_W-1:0] sel_f;
  logic [ADR_W-1:0] tgt_f;
  logic             pick;

  assign sel_f = word_i[ADR_W +: SEL_W];
  assign tgt_f = word_i[ADR_W-1:0];
  assign pick  = status_i[sel_f];

  // R2, R4: selected status high jumps to the target
  p_branch_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_vld_o && !we_i && pick) |=> (uaddr_o == $past(tgt_f)));

  // R3: selected status low falls through with wrap
  p_fall_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_vld_o && !we_i && !pick) |=> (uaddr_o == $past(uaddr_o) + ADR_W'(1)));

  // R6: a write edge freezes the presented state
  p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ($stable(uaddr_o) && $stable(uop_o)));

  // R6: a write edge drops valid
  p_write_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> !uop_vld_o);

  // R7: a refetch edge keeps the address
  p_refetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!uop_vld_o && !we_i) |=> $stable(uaddr_o));
endmodule

bind useq_top useq_checker i_useq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .status_i  (status_i),
  .we_i      (we_i),
  .uop_o     (uop_o),
  .uaddr_o   (uaddr_o),
  .uop_vld_o (uop_vld_o),
  .word_i    (word_q)
);

// File: tb/test_useq_top.sv
module test_useq_top;
  import useq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_COND-1:0] status_i = '0;
  logic              we_i = 1'b0;
  logic [ADR_W-1:0]  waddr_i = '0;
  logic [WORD_W-1:0] wdata_i = '0;
  logic [UOP_W-1:0]  uop_o;
  logic [ADR_W-1:0]  uaddr_o;
  logic              uop_vld_o;

  int checks = 0;
  int errors = 0;

  logic [WORD_W-1:0] m_mem [DEPTH];
  logic              m_s0 = 1'b0, m_s1 = 1'b0;
  logic [ADR_W-1:0]  m_car = '0;
  logic [WORD_W-1:0] m_word = '0;
  logic              m_run = 1'b0;

  always #5 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .we_i(we_i),
    .waddr_i(waddr_i), .wdata_i(wdata_i), .uop_o(uop_o),
    .uaddr_o(uaddr_o), .uop_vld_o(uop_vld_o)
  );

  function automatic logic [WORD_W-1:0] mk(input logic [UOP_W-1:0] op,
      input logic [SEL_W-1:0] s, input logic [ADR_W-1:0] t);
    return {op, s, t};
  endfunction

  // requirement-level next address: target on a selected 1, else +1 mod 1024
  function automatic logic [ADR_W-1:0] next_addr(input logic [WORD_W-1:0] w,
      input logic [N_COND-1:0] st, input logic [ADR_W-1:0] a);
    logic [SEL_W-1:0] s;
    s = w[ADR_W +: SEL_W];
    return st[s] ? w[ADR_W-1:0] : a + ADR_W'(1);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N_COND-1:0] st, input logic w,
      input logic [ADR_W-1:0] wa, input logic [WORD_W-1:0] wd, input string tag);
    logic              n_s0, n_s1, n_run;
    logic [ADR_W-1:0]  n_car;
    logic [WORD_W-1:0] n_word;
    status_i = st; we_i = w; waddr_i = wa; wdata_i = wd;
    n_car = m_car; n_word = m_word; n_run = m_run;
    if (!rst_n) begin
      n_s0 = 1'b0; n_s1 = 1'b0; n_car = '0; n_word = '0; n_run = 1'b0;
    end else begin
      n_s0 = 1'b1; n_s1 = m_s0;
      if (m_s1) begin
        if (w) begin
          n_run = 1'b0;
        end else begin
          n_car  = m_run ? next_addr(m_word, st, m_car) : m_car;
          n_word = m_mem[n_car];
          n_run  = 1'b1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (w) m_mem[wa] = wd;
    m_s0 = n_s0; m_s1 = n_s1; m_car = n_car; m_word = n_word; m_run = n_run;
    chk(tag, "uaddr_o", int'(uaddr_o), int'(m_car));
    chk("R1", "uop_o", int'(uop_o), int'(m_word[WORD_W-1 -: UOP_W]));
    chk(tag, "uop_vld_o", int'(uop_vld_o), int'(m_run));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R5/R6: load the whole store while reset is held, outputs stay zero
    for (int a = 0; a < int'(DEPTH); a++) begin
      logic [WORD_W-1:0] d;
      d = WORD_W'($urandom);
      if (a == 0) d = mk(13'h1A5, 3'd2, 10'd1023);
      if (a == int'(DEPTH) - 1) d = mk(13'h0F0, 3'd5, 10'd7);
      step('0, 1'b1, ADR_W'(a), d, "R5");
    end
    rst_n = 1'b1;
    step('1, 1'b0, '0, '0, "R5");
    step('1, 1'b0, '0, '0, "R5");
    step('1, 1'b0, '0, '0, "R5");    // R5: first fetch of word 0
    step(8'h04, 1'b0, '0, '0, "R2"); // bit 2 high: jump to 1023
    step(8'hDF, 1'b0, '0, '0, "R3"); // bit 5 low: 1023 wraps to 0
    // R6 then R7: patch the running word in place and refetch it
    step(8'hFF, 1'b1, m_car, mk(13'h1234, 3'd0, 10'd300), "R6");
    step(8'hFF, 1'b0, '0, '0, "R7");
    step(8'h01, 1'b0, '0, '0, "R2");
    // R4: every selector value reaches its own status line
    for (int k = 0; k < int'(N_COND); k++) begin
      step('0, 1'b1, m_car, mk(UOP_W'(k + 1), SEL_W'(k), ADR_W'(40 + k)), "R6");
      step('0, 1'b0, '0, '0, "R7");
      step(N_COND'(1) << k, 1'b0, '0, '0, "R4");
      step('0, 1'b1, m_car, mk(UOP_W'(k + 9), SEL_W'(k), ADR_W'(500)), "R6");
      step('0, 1'b0, '0, '0, "R7");
      step(~(N_COND'(1) << k), 1'b0, '0, '0, "R4");
    end
    // random phase: mixed status, occasional writes, some to the live address
    for (int i = 0; i < 3000; i++) begin
      logic              w;
      logic [ADR_W-1:0]  wa;
      logic [N_COND-1:0] st;
      string             tg;
      w  = ($urandom % 20) == 0;
      wa = (($urandom % 4) == 0) ? m_car : ADR_W'($urandom);
      st = N_COND'($urandom);
      if (w) tg = "R6";
      else if (!m_run) tg = "R7";
      else if (st[m_word[ADR_W +: SEL_W]]) tg = "R2";
      else tg = "R3";
      step(st, w, wa, WORD_W'($urandom), tg);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule